// File: doc/BRIEF.md
# Trap Context Save/Restore Unit

This block keeps the architectural context of a processor consistent across trap entry and trap return. When a trap is taken it captures the live program counter, the machine state word and the vector sub-program-counter (the loop state word) into a trio of save registers. In the same cycle it steers fetch to the trap vector supplied by the trap logic. When the handler returns, it hands the saved program counter and machine state word back to the pipeline and reloads the loop state word from its own save register, so that all three come back in one step.

There are two privilege levels, supervisor and hypervisor, and each owns a separate save-register trio. The loop state word is a full peer of the program counter and the machine state word. It has its own save register at each level and is never saved or restored on a different cycle from them. The block holds the architectural loop state word itself. In ordinary cycles it follows the live value from the loop engine. Trap entry forces it to zero so that the handler starts in scalar mode, and return reloads it from the matching save register.

In each cycle the request decoder picks one of five named actions: IDLE, TRAP_SUP, TRAP_HYP, RET_SUP or RET_HYP. The loop state register moves between three named update modes: FOLLOW (IDLE), CLEAR (either trap) and RESTORE (either return). A trap always takes priority over a return in the same cycle. The choice of trap cause and any rewriting of machine state bits belong to other blocks.

Top module: `trap_ctx_unit`

## Requirements
- R1: While reset is asserted and after it is released with no request, all six save registers read zero, `svstate` reads zero and `redirect` is low.
- R2: A supervisor trap (`trap_req`=1, `trap_hyp`=0) loads `srr_pc`, `srr_msr` and `srr_svs` from `cur_pc`, `cur_msr` and `cur_svs` at the clock edge, and the hypervisor trio keeps its value.
- R3: A hypervisor trap (`trap_req`=1, `trap_hyp`=1) loads `hsrr_pc`, `hsrr_msr` and `hsrr_svs` from the live values at the clock edge, and the supervisor trio keeps its value.
- R4: During any trap cycle, `redirect` is 1, `nxt_pc` equals `trap_vec` (for an illegal-instruction trap, 0x700) and `nxt_msr` equals `cur_msr`, all combinationally in that same cycle.
- R5: After a trap edge, `svstate` reads zero.
- R6: A supervisor return (`rfi_req`=1, `rfi_hyp`=0, no trap) drives `redirect`=1, `nxt_pc`=`srr_pc` and `nxt_msr`=`srr_msr` in the same cycle, and loads `svstate` from `srr_svs` at the edge. No save register changes.
- R7: A hypervisor return (`rfi_req`=1, `rfi_hyp`=1, no trap) does the same using `hsrr_pc`, `hsrr_msr` and `hsrr_svs`.
- R8: When `trap_req` and `rfi_req` are both 1, the trap is carried out as in R2 to R5 and the return is ignored.
- R9: In a cycle with no request, `redirect` is 0, `nxt_pc` equals `cur_pc`, `nxt_msr` equals `cur_msr`, `svstate` loads `cur_svs` at the edge and no save register changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trap_req | input | 1 | Trap entry request |
| trap_hyp | input | 1 | 1 selects the hypervisor save trio for the trap |
| trap_vec | input | PC_W | Trap vector address |
| rfi_req | input | 1 | Trap return request |
| rfi_hyp | input | 1 | 1 selects the hypervisor save trio for the return |
| cur_pc | input | PC_W | Live program counter |
| cur_msr | input | MSR_W | Live machine state word |
| cur_svs | input | SVS_W | Live loop state word from the loop engine |
| redirect | output | 1 | Fetch redirect valid this cycle |
| nxt_pc | output | PC_W | Next program counter |
| nxt_msr | output | MSR_W | Next machine state word |
| svstate | output | SVS_W | Architectural loop state word |
| srr_pc | output | PC_W | Supervisor saved program counter |
| srr_msr | output | MSR_W | Supervisor saved machine state word |
| srr_svs | output | SVS_W | Supervisor saved loop state word |
| hsrr_pc | output | PC_W | Hypervisor saved program counter |
| hsrr_msr | output | MSR_W | Hypervisor saved machine state word |
| hsrr_svs | output | SVS_W | Hypervisor saved loop state word |

## Verification
The bench uses the default widths: 64-bit program counter and machine state word, and a 32-bit loop state word. With these widths, the values written to one trio can be told apart from the other trio and from the live inputs in their upper bits as well as their lower bits. This exposes any crossed level select or truncated path. Distinct patterns in each field let the bench see a program counter that lands in the machine state slot, or a loop state word restored from the wrong level.

// File: rtl/trap_ctx_pkg.sv
package trap_ctx_pkg;

    typedef enum logic [2:0] {
        ACT_IDLE     = 3'd0,
        ACT_TRAP_SUP = 3'd1,
        ACT_TRAP_HYP = 3'd2,
        ACT_RET_SUP  = 3'd3,
        ACT_RET_HYP  = 3'd4
    } ctx_act_e;

    typedef enum logic [1:0] {
        SVS_FOLLOW  = 2'd0,
        SVS_CLEAR   = 2'd1,
        SVS_RESTORE = 2'd2
    } svs_mode_e;

    localparam int LVL_SUP = 0;
    localparam int LVL_HYP = 1;
    localparam int NUM_LVL = 2;

endpackage

// File: rtl/trap_ctx_arbiter.sv
module trap_ctx_arbiter
    import trap_ctx_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     trap_req,
    input  logic     trap_hyp,
    input  logic     rfi_req,
    input  logic     rfi_hyp,
    output ctx_act_e act,
    output logic     trap_go,
    output logic     ret_go,
    output logic     lvl_hyp
);

    always_comb begin
        act = ACT_IDLE;
        unique case ({trap_req, rfi_req})
            2'b10, 2'b11: act = trap_hyp ? ACT_TRAP_HYP : ACT_TRAP_SUP;
            2'b01:        act = rfi_hyp  ? ACT_RET_HYP  : ACT_RET_SUP;
            default:      act = ACT_IDLE;
        endcase
    end

    always_comb begin
        trap_go = 1'b0;
        ret_go  = 1'b0;
        lvl_hyp = 1'b0;
        unique case (act)
            ACT_TRAP_SUP: begin trap_go = 1'b1; lvl_hyp = 1'b0; end
            ACT_TRAP_HYP: begin trap_go = 1'b1; lvl_hyp = 1'b1; end
            ACT_RET_SUP:  begin ret_go  = 1'b1; lvl_hyp = 1'b0; end
            ACT_RET_HYP:  begin ret_go  = 1'b1; lvl_hyp = 1'b1; end
            default:      begin trap_go = 1'b0; ret_go = 1'b0; lvl_hyp = 1'b0; end
        endcase
    end

    // R8: a trap request always beats a return request
    a_r8_trap_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_req && rfi_req) |-> (trap_go && !ret_go && lvl_hyp == trap_hyp));

    // R8: never both actions at once
    a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(trap_go && ret_go));

endmodule

// File: rtl/trap_ctx_bank.sv
module trap_ctx_bank #(
    parameter int PC_W  = 64,
    parameter int MSR_W = 64,
    parameter int SVS_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [PC_W-1:0]  pc_in,
    input  logic [MSR_W-1:0] msr_in,
    input  logic [SVS_W-1:0] svs_in,
    output logic [PC_W-1:0]  pc_q,
    output logic [MSR_W-1:0] msr_q,
    output logic [SVS_W-1:0] svs_q
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q  <= '0;
            msr_q <= '0;
            svs_q <= '0;
        end else if (load) begin
            pc_q  <= pc_in;
            msr_q <= msr_in;
            svs_q <= svs_in;
        end
    end

    // R2 / R3: the whole trio is captured on one edge
    a_r2_r3_trio_load: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (pc_q == $past(pc_in) && msr_q == $past(msr_in)
                  && svs_q == $past(svs_in)));

    // R6 / R7 / R9: an unselected trio holds
    a_r9_trio_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> ($stable(pc_q) && $stable(msr_q) && $stable(svs_q)));

endmodule

// File: rtl/trap_ctx_svs.sv
module trap_ctx_svs
    import trap_ctx_pkg::*;
#(
    parameter int SVS_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             restore,
    input  logic [SVS_W-1:0] restore_val,
    input  logic [SVS_W-1:0] live,
    output logic [SVS_W-1:0] svs_q
);

    svs_mode_e        mode;
    logic [SVS_W-1:0] svs_d;

    always_comb begin
        if (clear)        mode = SVS_CLEAR;
        else if (restore) mode = SVS_RESTORE;
        else              mode = SVS_FOLLOW;
    end

    always_comb begin
        svs_d = live;
        unique case (mode)
            SVS_CLEAR:   svs_d = '0;
            SVS_RESTORE: svs_d = restore_val;
            SVS_FOLLOW:  svs_d = live;
            default:     svs_d = live;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) svs_q <= '0;
        else        svs_q <= svs_d;
    end

    // R5: trap entry leaves the handler in scalar mode
    a_r5_clear_on_trap: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (svs_q == '0));

    // R6 / R7: return reloads the saved word
    a_r6_r7_restore: assert property (@(posedge clk) disable iff (!rst_n)
        (restore && !clear) |=> (svs_q == $past(restore_val)));

    // R9: quiet cycles track the loop engine
    a_r9_follow: assert property (@(posedge clk) disable iff (!rst_n)
        (!restore && !clear) |=> (svs_q == $past(live)));

endmodule

// File: rtl/trap_ctx_unit.sv
module trap_ctx_unit
    import trap_ctx_pkg::*;
#(
    parameter int PC_W  = 64,
    parameter int MSR_W = 64,
    parameter int SVS_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trap_req,
    input  logic             trap_hyp,
    input  logic [PC_W-1:0]  trap_vec,
    input  logic             rfi_req,
    input  logic             rfi_hyp,
    input  logic [PC_W-1:0]  cur_pc,
    input  logic [MSR_W-1:0] cur_msr,
    input  logic [SVS_W-1:0] cur_svs,
    output logic             redirect,
    output logic [PC_W-1:0]  nxt_pc,
    output logic [MSR_W-1:0] nxt_msr,
    output logic [SVS_W-1:0] svstate,
    output logic [PC_W-1:0]  srr_pc,
    output logic [MSR_W-1:0] srr_msr,
    output logic [SVS_W-1:0] srr_svs,
    output logic [PC_W-1:0]  hsrr_pc,
    output logic [MSR_W-1:0] hsrr_msr,
    output logic [SVS_W-1:0] hsrr_svs
);

    ctx_act_e act;
    logic     trap_go;
    logic     ret_go;
    logic     lvl_hyp;

    logic [NUM_LVL-1:0] bank_load;
    logic [PC_W-1:0]    bank_pc  [NUM_LVL];
    logic [MSR_W-1:0]   bank_msr [NUM_LVL];
    logic [SVS_W-1:0]   bank_svs [NUM_LVL];

    logic [PC_W-1:0]    sel_pc;
    logic [MSR_W-1:0]   sel_msr;
    logic [SVS_W-1:0]   sel_svs;

    trap_ctx_arbiter u_arb (
        .clk      (clk),
        .rst_n    (rst_n),
        .trap_req (trap_req),
        .trap_hyp (trap_hyp),
        .rfi_req  (rfi_req),
        .rfi_hyp  (rfi_hyp),
        .act      (act),
        .trap_go  (trap_go),
        .ret_go   (ret_go),
        .lvl_hyp  (lvl_hyp)
    );

    for (genvar g = 0; g < NUM_LVL; g++) begin : g_lvl
        assign bank_load[g] = trap_go && (int'(lvl_hyp) == g);

        trap_ctx_bank #(
            .PC_W  (PC_W),
            .MSR_W (MSR_W),
            .SVS_W (SVS_W)
        ) u_bank (
            .clk    (clk),
            .rst_n  (rst_n),
            .load   (bank_load[g]),
            .pc_in  (cur_pc),
            .msr_in (cur_msr),
            .svs_in (cur_svs),
            .pc_q   (bank_pc[g]),
            .msr_q  (bank_msr[g]),
            .svs_q  (bank_svs[g])
        );
    end

    always_comb begin
        sel_pc  = lvl_hyp ? bank_pc[LVL_HYP]  : bank_pc[LVL_SUP];
        sel_msr = lvl_hyp ? bank_msr[LVL_HYP] : bank_msr[LVL_SUP];
        sel_svs = lvl_hyp ? bank_svs[LVL_HYP] : bank_svs[LVL_SUP];
    end

    trap_ctx_svs #(
        .SVS_W (SVS_W)
    ) u_svs (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear       (trap_go),
        .restore     (ret_go),
        .restore_val (sel_svs),
        .live        (cur_svs),
        .svs_q       (svstate)
    );

    always_comb begin
        redirect = 1'b0;
        nxt_pc   = cur_pc;
        nxt_msr  = cur_msr;
        unique case (act)
            ACT_TRAP_SUP, ACT_TRAP_HYP: begin
                redirect = 1'b1;
                nxt_pc   = trap_vec;
                nxt_msr  = cur_msr;
            end
            ACT_RET_SUP, ACT_RET_HYP: begin
                redirect = 1'b1;
                nxt_pc   = sel_pc;
                nxt_msr  = sel_msr;
            end
            default: begin
                redirect = 1'b0;
                nxt_pc   = cur_pc;
                nxt_msr  = cur_msr;
            end
        endcase
    end

    assign srr_pc   = bank_pc[LVL_SUP];
    assign srr_msr  = bank_msr[LVL_SUP];
    assign srr_svs  = bank_svs[LVL_SUP];
    assign hsrr_pc  = bank_pc[LVL_HYP];
    assign hsrr_msr = bank_msr[LVL_HYP];
    assign hsrr_svs = bank_svs[LVL_HYP];

    // R4: trap steers fetch to the vector in the same cycle
    a_r4_trap_redirect: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |-> (redirect && nxt_pc == trap_vec && nxt_msr == cur_msr));

    // R6: supervisor return hands back the supervisor trio
    a_r6_sup_return: assert property (@(posedge clk) disable iff (!rst_n)
        (rfi_req && !trap_req && !rfi_hyp) |->
            (redirect && nxt_pc == srr_pc && nxt_msr == srr_msr));

    // R7: hypervisor return hands back the hypervisor trio
    a_r7_hyp_return: assert property (@(posedge clk) disable iff (!rst_n)
        (rfi_req && !trap_req && rfi_hyp) |->
            (redirect && nxt_pc == hsrr_pc && nxt_msr == hsrr_msr));

    // R9: no request means no redirect
    a_r9_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!rfi_req && !trap_req) |-> (!redirect && nxt_pc == cur_pc));

    // R1: held in reset, every saved word is zero on the following edge
    a_r1_reset_clear: assert property (@(posedge clk)
        $past(!rst_n) |-> (svstate == '0 && srr_pc == '0 && hsrr_pc == '0
                           && srr_svs == '0 && hsrr_svs == '0));

endmodule

// File: tb/trap_ctx_unit_test.sv
module trap_ctx_unit_test;

    localparam int PERIOD = 10;
    localparam int PC_W   = 64;
    localparam int MSR_W  = 64;
    localparam int SVS_W  = 32;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             trap_req, trap_hyp, rfi_req, rfi_hyp;
    logic [PC_W-1:0]  trap_vec, cur_pc;
    logic [MSR_W-1:0] cur_msr;
    logic [SVS_W-1:0] cur_svs;
    logic             redirect;
    logic [PC_W-1:0]  nxt_pc, srr_pc, hsrr_pc;
    logic [MSR_W-1:0] nxt_msr, srr_msr, hsrr_msr;
    logic [SVS_W-1:0] svstate, srr_svs, hsrr_svs;

    int checks = 0;
    int errors = 0;

    // bench-side model of the save trios
    logic [PC_W-1:0]  m_spc = '0, m_hpc = '0;
    logic [MSR_W-1:0] m_smsr = '0, m_hmsr = '0;
    logic [SVS_W-1:0] m_ssvs = '0, m_hsvs = '0;

    always #(PERIOD/2) clk = ~clk;

    trap_ctx_unit #(.PC_W(PC_W), .MSR_W(MSR_W), .SVS_W(SVS_W)) uut (
        .clk(clk), .rst_n(rst_n),
        .trap_req(trap_req), .trap_hyp(trap_hyp), .trap_vec(trap_vec),
        .rfi_req(rfi_req), .rfi_hyp(rfi_hyp),
        .cur_pc(cur_pc), .cur_msr(cur_msr), .cur_svs(cur_svs),
        .redirect(redirect), .nxt_pc(nxt_pc), .nxt_msr(nxt_msr),
        .svstate(svstate),
        .srr_pc(srr_pc), .srr_msr(srr_msr), .srr_svs(srr_svs),
        .hsrr_pc(hsrr_pc), .hsrr_msr(hsrr_msr), .hsrr_svs(hsrr_svs)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic chk_trios(input string tag);
        chk({tag, " srr_pc"},   srr_pc,   m_spc);
        chk({tag, " srr_msr"},  srr_msr,  m_smsr);
        chk({tag, " srr_svs"},  64'(srr_svs),  64'(m_ssvs));
        chk({tag, " hsrr_pc"},  hsrr_pc,  m_hpc);
        chk({tag, " hsrr_msr"}, hsrr_msr, m_hmsr);
        chk({tag, " hsrr_svs"}, 64'(hsrr_svs), 64'(m_hsvs));
    endtask

    task automatic quiet();
        trap_req = 0; trap_hyp = 0; rfi_req = 0; rfi_hyp = 0;
    endtask

    // advance to the next falling edge (one rising edge in between)
    task automatic step();
        @(negedge clk);
    endtask

    task automatic t_reset();
        rst_n = 0; quiet();
        trap_vec = 64'h700; cur_pc = 64'h1000; cur_msr = 64'h8000_0000_0000_0001;
        cur_svs = 32'h5555_AAAA;
        step(); step();
        chk_trios("R1 in reset");
        chk("R1 svstate", 64'(svstate), 64'h0);
        rst_n = 1;
        #1;
        chk("R1 redirect", 64'(redirect), 64'h0);
    endtask

    task automatic t_idle(input logic [SVS_W-1:0] sv);
        quiet(); cur_svs = sv; cur_pc = 64'hCAFE_0000_0000_1230;
        #1;
        chk("R9 redirect", 64'(redirect), 64'h0);
        chk("R9 nxt_pc", nxt_pc, cur_pc);
        chk("R9 nxt_msr", nxt_msr, cur_msr);
        step();
        chk("R9 svstate follows", 64'(svstate), 64'(sv));
        chk_trios("R9 hold");
    endtask

    task automatic t_trap(input logic hyp, input logic also_ret, input logic ret_hyp,
                          input logic [PC_W-1:0] pc, input logic [MSR_W-1:0] msr,
                          input logic [SVS_W-1:0] sv);
        string tg;
        tg = also_ret ? "R8" : (hyp ? "R3" : "R2");
        cur_pc = pc; cur_msr = msr; cur_svs = sv; trap_vec = 64'h700;
        trap_req = 1; trap_hyp = hyp; rfi_req = also_ret; rfi_hyp = ret_hyp;
        #1;
        chk({tg, " R4 redirect"}, 64'(redirect), 64'h1);
        chk({tg, " R4 nxt_pc vector"}, nxt_pc, 64'h700);
        chk({tg, " R4 nxt_msr"}, nxt_msr, msr);
        if (hyp) begin m_hpc = pc; m_hmsr = msr; m_hsvs = sv; end
        else     begin m_spc = pc; m_smsr = msr; m_ssvs = sv; end
        step();
        quiet();
        chk_trios({tg, " save"});
        chk({tg, " R5 svstate cleared"}, 64'(svstate), 64'h0);
    endtask

    task automatic t_return(input logic hyp);
        string tg;
        tg = hyp ? "R7" : "R6";
        cur_pc = 64'h0BAD_0BAD_0BAD_0BAD; cur_msr = 64'h1111; cur_svs = 32'h7777_7777;
        trap_req = 0; rfi_req = 1; rfi_hyp = hyp;
        #1;
        chk({tg, " redirect"}, 64'(redirect), 64'h1);
        chk({tg, " nxt_pc"}, nxt_pc, hyp ? m_hpc : m_spc);
        chk({tg, " nxt_msr"}, nxt_msr, hyp ? m_hmsr : m_smsr);
        step();
        quiet();
        chk({tg, " svstate restored"}, 64'(svstate), 64'(hyp ? m_hsvs : m_ssvs));
        chk_trios({tg, " unchanged"});
    endtask

    initial begin
        #(PERIOD * 20000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_idle(32'h0000_1234);
        t_idle(32'hFEDC_0001);
        t_trap(1'b0, 1'b0, 1'b0, 64'h0000_0001_0000_0A40, 64'hA000_0000_0000_0033, 32'h0003_0102);
        t_trap(1'b1, 1'b0, 1'b0, 64'hFFFF_8000_0000_2000, 64'h9000_0000_1000_0001, 32'hC0DE_0005);
        t_idle(32'h0000_00FF);
        t_return(1'b0);
        t_return(1'b1);
        t_trap(1'b0, 1'b1, 1'b1, 64'h0000_0000_DEAD_0004, 64'h0000_0000_0000_F00D, 32'h0101_0101);
        t_return(1'b0);
        t_trap(1'b1, 1'b1, 1'b0, 64'h1234_5678_9ABC_DEF0, 64'h0F0F_0F0F_0F0F_0F0F, 32'h8000_0001);
        t_return(1'b1);
        t_idle(32'h0000_0042);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule